// File: doc/BRIEF.md
# Write-Path Parity Generator/Checker

This block sits on the write side of a word-wide FIFO. It takes each incoming word, which is a payload plus one spare bit at the top, and rewrites that top bit before the word goes into storage. A three-bit configuration chooses what happens to it. When processing is off, the word passes through untouched. When generating, the top bit is replaced by a parity bit computed over the payload. When checking, the whole word is tested and the top bit is replaced by a pass/fail flag.

The top bit is stored with the payload, so it comes back out on the ninth read bit. Downstream logic reads it as either the generated parity or the check result. The block is purely combinational from input word to stored word and adds no write latency. The write strobe is forwarded unchanged beside the processed word.

Top module: `wpar_unit`

## Requirements
- R1: When `cfg[2]` (enable) is 0, `store_word` equals `wr_word` in every bit, whatever `cfg[1:0]` holds.
- R2: When `cfg[2:1]` is 2'b10 (generate) and `cfg[0]` is 0 (even), `store_word[DATA_W]` is set so that the total number of ones across all `DATA_W+1` stored bits is even.
- R3: When `cfg[2:1]` is 2'b10 and `cfg[0]` is 1 (odd), `store_word[DATA_W]` is set so that the total number of ones across all stored bits is odd.
- R4: When `cfg[2:1]` is 2'b11 (check) and `cfg[0]` is 0 (even), `store_word[DATA_W]` is 0 if the count of ones in all `DATA_W+1` incoming bits is odd (error), and 1 otherwise.
- R5: When `cfg[2:1]` is 2'b11 and `cfg[0]` is 1 (odd), `store_word[DATA_W]` is 0 if the count of ones in all incoming bits is even (error), and 1 otherwise.
- R6: In every configuration, `store_word[DATA_W-1:0]` equals `wr_word[DATA_W-1:0]`.
- R7: In generate mode, the incoming top bit `wr_word[DATA_W]` has no effect on `store_word`.
- R8: `store_we` equals `wr_en`, and `store_word` follows its inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg | input | 3 | Configuration: [2] enable, [1] 1 = check / 0 = generate, [0] 1 = odd / 0 = even |
| wr_en | input | 1 | Write strobe from the producer |
| wr_word | input | DATA_W+1 | Incoming word; the top bit is the spare parity/flag bit |
| store_we | output | 1 | Write strobe to storage |
| store_word | output | DATA_W+1 | Processed word to be stored |

## Verification
The bench builds the block with the default DATA_W of 8. At that width the input space is small: 512 word values times 8 configurations. The bench therefore runs every combination, with the strobe toggled between them. This reaches every pass-through, generate and check case, including the all-zero and all-one payloads and both values of the incoming top bit. It also confirms that the top bit is ignored in generate mode and that no payload bit is ever altered.

// File: rtl/wpar_unit.sv
module wpar_unit #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]      cfg,
  input  logic            wr_en,
  input  logic [DATA_W:0] wr_word,
  output logic            store_we,
  output logic [DATA_W:0] store_word
);

  localparam int TOP = DATA_W;

  logic en, chk, odd;
  logic pay_par, full_par, gen_bit, ok_bit, top_bit;

  assign en  = cfg[2];
  assign chk = cfg[1];
  assign odd = cfg[0];

  assign pay_par  = ^wr_word[TOP-1:0];
  assign full_par = pay_par ^ wr_word[TOP];

  assign gen_bit = pay_par ^ odd;
  assign ok_bit  = ~(full_par ^ odd);

  always_comb begin
    if (!en)      top_bit = wr_word[TOP];
    else if (chk) top_bit = ok_bit;
    else          top_bit = gen_bit;
  end

  assign store_word = {top_bit, wr_word[TOP-1:0]};
  assign store_we   = wr_en;

endmodule

module wpar_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic [2:0]      cfg,
  input logic            wr_en,
  input logic [DATA_W:0] wr_word,
  input logic            store_we,
  input logic [DATA_W:0] store_word
);

  always_comb begin
    if (!cfg[2])
      AST_OFF_PASS: assert (store_word == wr_word); // R1
    if (cfg[2:1] == 2'b10 && !cfg[0])
      AST_GEN_EVEN: assert (($countones(store_word) % 2) == 0); // R2
    if (cfg[2:1] == 2'b10 && cfg[0])
      AST_GEN_ODD: assert (($countones(store_word) % 2) == 1); // R3
    if (cfg == 3'b110)
      AST_CHK_EVEN: assert (store_word[DATA_W] == (($countones(wr_word) % 2) == 0)); // R4
    if (cfg == 3'b111)
      AST_CHK_ODD: assert (store_word[DATA_W] == (($countones(wr_word) % 2) == 1)); // R5
    AST_PAYLOAD_KEPT: assert (store_word[DATA_W-1:0] == wr_word[DATA_W-1:0]); // R6
    AST_STROBE_THRU: assert (store_we == wr_en); // R8
  end

endmodule

bind wpar_unit wpar_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .cfg(cfg), .wr_en(wr_en), .wr_word(wr_word),
  .store_we(store_we), .store_word(store_word)
);

// File: tb/wpar_unit_test.sv
module wpar_unit_test;
  localparam int DW = 8;

  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic [2:0]  cfg = '0;
  logic        wr_en = 0;
  logic [DW:0] wr_word = '0;
  logic        store_we;
  logic [DW:0] store_word;

  wpar_unit #(.DATA_W(DW)) uut (
    .cfg(cfg), .wr_en(wr_en), .wr_word(wr_word),
    .store_we(store_we), .store_word(store_word)
  );

  typedef struct packed {
    logic [2:0]  c;
    logic        we;
    logic [DW:0] w;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic string req_of(logic [2:0] c);
    if (!c[2])          return "R1";
    if (c == 3'b100)    return "R2/R7";
    if (c == 3'b101)    return "R3/R7";
    if (c == 3'b110)    return "R4";
    return "R5";
  endfunction

  function automatic logic [DW:0] model(logic [2:0] c, logic [DW:0] w);
    int ones = 0;
    int all = 0;
    logic t;
    for (int i = 0; i < DW; i++) ones += w[i];
    all = ones + w[DW];
    if (!c[2])       t = w[DW];
    else if (!c[1])  t = c[0] ? ((ones % 2) == 0) : ((ones % 2) == 1);
    else             t = c[0] ? ((all % 2) == 1) : ((all % 2) == 0);
    return {t, w[DW-1:0]};
  endfunction

  task automatic drive(input logic [2:0] c, input logic we, input logic [DW:0] w);
    item_t it;
    @(posedge clk); #1;
    cfg = c; wr_en = we; wr_word = w;
    it.c = c; it.we = we; it.w = w;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [DW:0] exp;
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        it = q.pop_front();
        exp = model(it.c, it.w);
        n_run++;
        if (store_word !== exp) begin
          n_fail++;
          $display("FAIL %s cfg=%b in=%h got=%h exp=%h", req_of(it.c), it.c, it.w, store_word, exp);
        end
        if (store_word[DW-1:0] !== it.w[DW-1:0]) begin
          n_fail++;
          $display("FAIL R6 payload got=%h exp=%h", store_word[DW-1:0], it.w[DW-1:0]);
        end
        n_run++;
        if (store_we !== it.we) begin
          n_fail++;
          $display("FAIL R8 strobe got=%b exp=%b", store_we, it.we);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (store_word !== '0 || store_we !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state got=%h/%b exp=000/0", store_word, store_we);
    end
    rst_n = 1;
    // corner words: all zero / all one payload, both top-bit values
    drive(3'b100, 1, 9'h000); drive(3'b100, 1, 9'h100); // R7
    drive(3'b101, 1, 9'h0FF); drive(3'b101, 1, 9'h1FF); // R3
    drive(3'b110, 1, 9'h101); drive(3'b111, 1, 9'h101); // R4 R5
    drive(3'b011, 1, 9'h155); // R1
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < (1 << (DW + 1)); w++)
        drive(c[2:0], w[0] ^ c[0], w[DW:0]);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule